// File: doc/BRIEF.md
# Timer Count-Clock Source Selector

This block decides when a timer time base may advance. Each cycle of the timer kernel clock it raises or lowers a single-cycle `tick` strobe, which the prescaler and counter downstream use as their count enable. The count source is one of three. The first is the kernel clock itself, which gives a tick on every cycle. The second is a conditioned external trigger pin. The third is a trigger input picked from a multiplexer.

Every asynchronous input first passes through a two-flop synchronizer. The pin path then applies an optional inversion and a digital glitch filter. After the filter it detects rising edges and divides them by a power of two. The trigger multiplexer chooses among this conditioned pin stream, the rising edges of four inter-timer trigger lines (each the trigger output of another timer), every edge of filtered channel 1, and the rising edges of filtered channel 1 or channel 2.

Each glitch filter is a four-state machine with the states FLT_LOW, FLT_RISE, FLT_HIGH and FLT_FALL. FLT_LOW goes to FLT_RISE when it sees a high sample, or straight to FLT_HIGH when the run length is one. FLT_RISE returns to FLT_LOW on a low sample and goes on to FLT_HIGH once the run is complete. FLT_HIGH and FLT_FALL mirror these transitions for the falling direction. The filtered level is high in FLT_HIGH and FLT_FALL.

Top module: `tcs_top`

## Requirements
- R1: While `rst_n` is low, `tick` is 0.
- R2: When `clk_mode` is 0 (internal) or 3 (spare, treated as internal), `tick` is 1 in every cycle after the first clock edge that follows reset.
- R3: When `clk_mode` is 2 (pin mode), ticks come only from the conditioned pin stream, and `trig_sel` has no effect.
- R4: When `pin_invert` is 0, rising edges of `ext_pin` are counted. When it is 1, falling edges are counted.
- R5: A glitch filter changes its output only after N consecutive samples at the new level, where N = 1, 2, 4 or 8 for a filter code of 0, 1, 2 or 3. A pulse shorter than N cycles produces no tick. The pin uses `pin_flt` and both channels use `ch_flt`.
- R6: The pin prescaler emits one tick per 2^`pin_psc` filtered rising edges (division by 1, 2, 4 or 8), counting from reset.
- R7: When `clk_mode` is 1 (trigger mode) and `trig_sel` is 1 to 4, each rising edge of `xtrig[trig_sel-1]` produces one tick, and the other `xtrig` lines are ignored.
- R8: In trigger mode with `trig_sel` set to 5, both rising and falling edges of filtered `ch1_in` produce one tick each.
- R9: In trigger mode, `trig_sel` set to 6 counts rising edges of filtered `ch1_in`, and `trig_sel` set to 7 counts rising edges of filtered `ch2_in`. The unselected channel is ignored.
- R10: In pin mode with `pin_psc` at 0, a level change on `ext_pin` set up before clock edge k makes `tick` high in exactly the cycle after edge k+2+N.
- R11: Each counted source edge gives a tick that lasts exactly one cycle.
- R12: In trigger mode with `trig_sel` set to 0, the conditioned pin stream is used, with the same count as pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 2 | 0 internal, 1 trigger mode, 2 pin mode, 3 internal |
| trig_sel | input | 3 | Trigger source: 0 pin, 1-4 xtrig, 5 ch1 any edge, 6 ch1, 7 ch2 |
| pin_invert | input | 1 | Invert the trigger pin before filtering |
| pin_flt | input | 2 | Pin filter run length code (N = 2^code) |
| pin_psc | input | 2 | Pin edge divider code (divide by 2^code) |
| ch_flt | input | 2 | Channel filter run length code (N = 2^code) |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| xtrig | input | 4 | Asynchronous inter-timer trigger lines |
| ch1_in | input | 1 | Asynchronous channel 1 input |
| ch2_in | input | 1 | Asynchronous channel 2 input |
| tick | output | 1 | Single-cycle count enable |

## Verification
The bench sweeps every combination of pin polarity, filter length and prescaler with a fixed pulse train, and checks the tick count against 16 >> code. A swapped polarity, a wrong divider or an off-by-one filter threshold changes that count. Pulses exactly one cycle shorter than the filter run length must produce nothing. Pulses of exactly the run length must each pass, which catches a filter that accepts a run one cycle early or one cycle late. The pin-to-tick latency is measured cycle by cycle for each filter length, so an extra or missing pipeline register shows up. Each trigger-multiplexer code is driven while the neighbouring sources are toggled, which exposes a mis-wired select or an edge detector that also fires on the wrong polarity.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        CKM_INTERNAL = 2'd0,
        CKM_TRIGGER  = 2'd1,
        CKM_PIN      = 2'd2,
        CKM_SPARE    = 2'd3
    } ckmode_e;

    typedef enum logic [1:0] {
        FLT_LOW  = 2'd0,
        FLT_RISE = 2'd1,
        FLT_HIGH = 2'd2,
        FLT_FALL = 2'd3
    } flt_state_e;

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        pipe[0] <= din;
        for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/tcs_glitch_filter.sv
module tcs_glitch_filter
    import tcs_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] run_sel,
    input  logic             din,
    output logic             level,
    output logic             changed
);
    localparam int MAX_N = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W = (MAX_N > 2) ? $clog2(MAX_N) : 1;

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] need_m1;
    logic             level_q;

    always_comb begin
        need_m1 = CNT_W'((32'd1 << run_sel) - 32'd1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_LOW: begin
                if (din) begin
                    if (need_m1 == '0) begin
                        state_d = FLT_HIGH;
                        cnt_d   = '0;
                    end else begin
                        state_d = FLT_RISE;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FLT_RISE: begin
                if (!din) begin
                    state_d = FLT_LOW;
                    cnt_d   = '0;
                end else if (cnt_q >= need_m1) begin
                    state_d = FLT_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FLT_HIGH: begin
                if (!din) begin
                    if (need_m1 == '0) begin
                        state_d = FLT_LOW;
                        cnt_d   = '0;
                    end else begin
                        state_d = FLT_FALL;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FLT_FALL: begin
                if (din) begin
                    state_d = FLT_HIGH;
                    cnt_d   = '0;
                end else if (cnt_q >= need_m1) begin
                    state_d = FLT_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = FLT_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level;
        end
    end

    // outputs
    always_comb begin
        level   = (state_q == FLT_HIGH) || (state_q == FLT_FALL);
        changed = level ^ level_q;
    end

    AST_FLT_ACCEPT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(din) == level)); // R5

    AST_FLT_PENDING_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_RISE) |-> $past(din)); // R5
endmodule

// File: rtl/tcs_edge_prescaler.sv
module tcs_edge_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             edge_i,
    output logic             tick_o
);
    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_m1;

    always_comb begin
        div_m1 = CNT_W'((32'd1 << div_sel) - 32'd1);
        tick_o = edge_i && (cnt_q >= div_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (edge_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    AST_PSC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

    AST_PSC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(cnt_q)); // R6

    AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tcs_top.sv
module tcs_top
    import tcs_pkg::*;
#(
    parameter int XTRIG_N     = 4,
    parameter int FLT_SEL_W   = 2,
    parameter int PSC_SEL_W   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int TSEL_W     = $clog2(XTRIG_N + 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           clk_mode,
    input  logic [TSEL_W-1:0]    trig_sel,
    input  logic                 pin_invert,
    input  logic [FLT_SEL_W-1:0] pin_flt,
    input  logic [PSC_SEL_W-1:0] pin_psc,
    input  logic [FLT_SEL_W-1:0] ch_flt,
    input  logic                 ext_pin,
    input  logic [XTRIG_N-1:0]   xtrig,
    input  logic                 ch1_in,
    input  logic                 ch2_in,
    output logic                 tick
);
    localparam int SEL_CH1_ANY = XTRIG_N + 1;
    localparam int SEL_CH1     = XTRIG_N + 2;
    localparam int SEL_CH2     = XTRIG_N + 3;

    // synchronizers
    logic               pin_s, ch1_s, ch2_s;
    logic [XTRIG_N-1:0] xt_s;

    tcs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_pin (
        .clk(clk), .din(ext_pin), .dout(pin_s));
    tcs_sync #(.W(XTRIG_N), .STAGES(SYNC_STAGES)) u_sync_xt (
        .clk(clk), .din(xtrig), .dout(xt_s));
    tcs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ch1 (
        .clk(clk), .din(ch1_in), .dout(ch1_s));
    tcs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ch2 (
        .clk(clk), .din(ch2_in), .dout(ch2_s));

    // pin path: polarity, filter, rising edge, divider
    logic pin_pol, pin_lvl, pin_chg, pin_rise, pin_tick;

    assign pin_pol  = pin_s ^ pin_invert;
    assign pin_rise = pin_chg & pin_lvl;

    tcs_glitch_filter #(.SEL_W(FLT_SEL_W)) u_flt_pin (
        .clk(clk), .rst_n(rst_n), .run_sel(pin_flt), .din(pin_pol),
        .level(pin_lvl), .changed(pin_chg));

    tcs_edge_prescaler #(.SEL_W(PSC_SEL_W)) u_psc_pin (
        .clk(clk), .rst_n(rst_n), .div_sel(pin_psc), .edge_i(pin_rise),
        .tick_o(pin_tick));

    // channel filters
    logic ch1_lvl, ch1_chg, ch2_lvl, ch2_chg;

    tcs_glitch_filter #(.SEL_W(FLT_SEL_W)) u_flt_ch1 (
        .clk(clk), .rst_n(rst_n), .run_sel(ch_flt), .din(ch1_s),
        .level(ch1_lvl), .changed(ch1_chg));

    tcs_glitch_filter #(.SEL_W(FLT_SEL_W)) u_flt_ch2 (
        .clk(clk), .rst_n(rst_n), .run_sel(ch_flt), .din(ch2_s),
        .level(ch2_lvl), .changed(ch2_chg));

    // inter-timer rising edges
    logic [XTRIG_N-1:0] xt_q, xt_rise;

    for (genvar g = 0; g < XTRIG_N; g++) begin : g_xt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) xt_q[g] <= 1'b0;
            else        xt_q[g] <= xt_s[g];
        end
        assign xt_rise[g] = xt_s[g] & ~xt_q[g];

        AST_XT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            xt_rise[g] |=> !xt_rise[g]); // R11
    end

    // trigger multiplexer
    logic trig_pulse;
    int   sel_int;

    always_comb begin
        sel_int    = int'(trig_sel);
        trig_pulse = 1'b0;
        if (sel_int == 0) begin
            trig_pulse = pin_tick;
        end
        for (int i = 0; i < XTRIG_N; i++) begin
            if (sel_int == i + 1) trig_pulse = xt_rise[i];
        end
        if (sel_int == SEL_CH1_ANY) trig_pulse = ch1_chg;
        if (sel_int == SEL_CH1)     trig_pulse = ch1_chg & ch1_lvl;
        if (sel_int == SEL_CH2)     trig_pulse = ch2_chg & ch2_lvl;
    end

    // mode decode and tick output
    ckmode_e mode_e;
    logic    tick_d, tick_q;

    always_comb begin
        mode_e = ckmode_e'(clk_mode);
        tick_d = 1'b0;
        unique case (mode_e)
            CKM_INTERNAL: tick_d = 1'b1;
            CKM_TRIGGER:  tick_d = trig_pulse;
            CKM_PIN:      tick_d = pin_tick;
            CKM_SPARE:    tick_d = 1'b1;
            default:      tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick = tick_q;

    AST_INT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_mode == 2'd0) || (clk_mode == 2'd3)) |=> tick); // R2

    AST_PIN_ONLY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_mode == 2'd2) && !pin_tick) |=> !tick); // R3

    AST_PIN_TICK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_mode == 2'd2) && pin_tick) |=> tick); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !tick); // R1
endmodule

// File: tb/tcs_top_tb.sv
`timescale 1ns/1ps
module tcs_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_mode = 2'd0;
    logic [2:0] trig_sel = 3'd0;
    logic       pin_invert = 1'b0;
    logic [1:0] pin_flt = 2'd0;
    logic [1:0] pin_psc = 2'd0;
    logic [1:0] ch_flt = 2'd0;
    logic       ext_pin = 1'b0;
    logic [3:0] xtrig = 4'd0;
    logic       ch1_in = 1'b0;
    logic       ch2_in = 1'b0;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;

    always #4 clk = ~clk;

    tcs_top u_dut (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .trig_sel(trig_sel),
        .pin_invert(pin_invert), .pin_flt(pin_flt), .pin_psc(pin_psc),
        .ch_flt(ch_flt), .ext_pin(ext_pin), .xtrig(xtrig), .ch1_in(ch1_in),
        .ch2_in(ch2_in), .tick(tick));

    always @(negedge clk) if (tick) tick_cnt <= tick_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // which: 0 pin, 1..4 xtrig, 5 ch1, 6 ch2
    task automatic drive(input int which, input logic v);
        case (which)
            0: ext_pin = v;
            1, 2, 3, 4: xtrig[which-1] = v;
            5: ch1_in = v;
            default: ch2_in = v;
        endcase
    endtask

    task automatic pulses(input int which, input int n, input int hi, input int lo, input logic idle);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            drive(which, ~idle);
            repeat (hi) @(negedge clk);
            drive(which, idle);
            repeat (lo - 1) @(negedge clk);
        end
        repeat (25) @(negedge clk);
    endtask

    task automatic latency(input int f);
        int n;
        n = 1 << f;
        clk_mode = 2'd2; pin_psc = 2'd0; pin_flt = 2'(f); pin_invert = 1'b0;
        ext_pin = 1'b0;
        do_reset();
        ext_pin = 1'b1;
        repeat (n + 2) @(posedge clk);
        @(negedge clk);
        chk("R10 before", int'(tick), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 at", int'(tick), 1);
        @(negedge clk);
        chk("R11 width", int'(tick), 0);
        ext_pin = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int base;
        // R1 and R2: reset then internal modes
        clk_mode = 2'd0;
        repeat (3) @(negedge clk);
        chk("R1", int'(tick), 0);
        do_reset();
        base = tick_cnt;
        repeat (40) @(negedge clk);
        chk("R2 mode0", tick_cnt - base, 40);
        clk_mode = 2'd3;
        do_reset();
        base = tick_cnt;
        repeat (40) @(negedge clk);
        chk("R2 mode3", tick_cnt - base, 40);

        // R3 R4 R5 R6: sweep polarity, filter, prescaler in pin mode
        for (int inv = 0; inv < 2; inv++) begin
            for (int f = 0; f < 4; f++) begin
                for (int ps = 0; ps < 4; ps++) begin
                    clk_mode = 2'd2; trig_sel = 3'(ps + 3);
                    pin_invert = 1'(inv); pin_flt = 2'(f); pin_psc = 2'(ps);
                    ext_pin = 1'(inv);
                    do_reset();
                    base = tick_cnt;
                    pulses(0, 16, 10, 10, 1'(inv));
                    chk(inv ? "R4 R6 sweep" : "R3 R6 sweep", tick_cnt - base, 16 >> ps);
                end
            end
        end

        // R5: pulses one cycle short are rejected, exact length accepted
        for (int f = 1; f < 4; f++) begin
            clk_mode = 2'd2; pin_invert = 1'b0; pin_flt = 2'(f); pin_psc = 2'd0;
            ext_pin = 1'b0;
            do_reset();
            base = tick_cnt;
            pulses(0, 4, (1 << f) - 1, 14, 1'b0);
            chk("R5 short", tick_cnt - base, 0);
            base = tick_cnt;
            pulses(0, 4, 1 << f, 14, 1'b0);
            chk("R5 exact", tick_cnt - base, 4);
        end

        // R10 R11: latency per filter length
        for (int f = 0; f < 4; f++) latency(f);

        // R7: inter-timer selection
        for (int s = 1; s <= 4; s++) begin
            clk_mode = 2'd1; trig_sel = 3'(s);
            do_reset();
            base = tick_cnt;
            pulses(s, 5, 3, 5, 1'b0);
            chk("R7 selected", tick_cnt - base, 5);
            base = tick_cnt;
            pulses((s % 4) + 1, 3, 3, 5, 1'b0);
            pulses(5, 2, 3, 5, 1'b0);
            chk("R7 others ignored", tick_cnt - base, 0);
        end

        // R8: both edges of ch1
        clk_mode = 2'd1; trig_sel = 3'd5; ch_flt = 2'd1;
        do_reset();
        base = tick_cnt;
        pulses(5, 5, 4, 6, 1'b0);
        chk("R8 any edge", tick_cnt - base, 10);

        // R9: filtered channel rising edges
        trig_sel = 3'd6; ch_flt = 2'd2;
        do_reset();
        base = tick_cnt;
        pulses(5, 5, 6, 8, 1'b0);
        chk("R9 ch1", tick_cnt - base, 5);
        base = tick_cnt;
        pulses(6, 3, 6, 8, 1'b0);
        chk("R9 ch2 ignored", tick_cnt - base, 0);
        trig_sel = 3'd7;
        do_reset();
        base = tick_cnt;
        pulses(6, 5, 6, 8, 1'b0);
        chk("R9 ch2", tick_cnt - base, 5);
        base = tick_cnt;
        pulses(6, 3, 3, 8, 1'b0);
        chk("R9 ch2 short", tick_cnt - base, 0);

        // R12: trigger mode select 0 uses the pin path
        clk_mode = 2'd1; trig_sel = 3'd0; pin_invert = 1'b0; pin_flt = 2'd1; pin_psc = 2'd1;
        ext_pin = 1'b0;
        do_reset();
        base = tick_cnt;
        pulses(0, 8, 5, 5, 1'b0);
        chk("R12 pin via trigger", tick_cnt - base, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule